// File: doc/BRIEF.md
# Multiplexed Digit Display Refresh Controller

This block keeps a sixteen-byte display store that a host fills one byte at a time, and it drives an external multiplexed digit display from that store. On every scan slot the block presents the byte of the digit being scanned as two 4-bit nibble buses, an upper and a lower half. It uses the same scan index that a neighbouring keyboard scanner steps, so each digit is driven only during its own slot. The scan wraps after either eight or sixteen digits, as the mode input selects.

The host writes through a pointer that it can load and that advances after each write. Either nibble of a write can be protected so that its stored bits are kept. Either output nibble can be blanked without touching the store. A clear request wipes the store to the blank code (all zeros) at one byte per clock. While the clear runs the block reports busy and blanks both halves of the display.

Top module: `disp_refresh`

## Requirements
- R1: After reset the scan index is 0, busy is low, both nibble buses read 0 and every store byte is 0.
- R2: Each cycle with `scan_step` high, `scan_idx` goes up by one. It returns to 0 after the last digit, which is 15 when `digits16` is 1 and 7 when it is 0. If the index is already past the last digit when a step comes, it also returns to 0. Without a step the index holds.
- R3: An accepted write stores `wr_data` at the write pointer and then advances the pointer by one, modulo 16. An accepted `ptr_load` sets the pointer to `ptr_addr`. When `ptr_load` and `wr_en` come together, the load wins and the write is dropped.
- R4: With `inh_hi` high, a write keeps the stored bits 7:4. With `inh_lo` high, a write keeps the stored bits 3:0. The pointer still advances in both cases.
- R5: In the cycle the scan index changes, `dig_hi` shows bits 7:4 and `dig_lo` shows bits 3:0 of the store byte at `scan_idx`.
- R6: `blank_hi` forces `dig_hi` to 0 and `blank_lo` forces `dig_lo` to 0, each on its own, without changing the store. While busy, both halves are forced to 0. `blanked_hi` and `blanked_lo` report the forced state of each half.
- R7: A `clr_req` accepted while idle takes priority over a write or a load in the same cycle and resets the write pointer to 0. From the next cycle, `busy` stays high for exactly 16 cycles. During those cycles bytes 0 to 15 are zeroed in order, one per clock, whatever the inhibit settings.
- R8: While busy, `wr_en`, `ptr_load` and `clr_req` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_step | input | 1 | Advance the scan index by one slot |
| digits16 | input | 1 | 1: sixteen digits, 0: eight digits |
| wr_en | input | 1 | Write `wr_data` at the pointer |
| wr_data | input | 8 | Host byte |
| ptr_load | input | 1 | Load the write pointer |
| ptr_addr | input | 4 | New pointer value |
| inh_hi | input | 1 | Protect bits 7:4 on writes |
| inh_lo | input | 1 | Protect bits 3:0 on writes |
| blank_hi | input | 1 | Blank the upper output nibble |
| blank_lo | input | 1 | Blank the lower output nibble |
| clr_req | input | 1 | Start clearing the store |
| scan_idx | output | 4 | Current scan slot |
| dig_hi | output | 4 | Upper nibble of the scanned digit |
| dig_lo | output | 4 | Lower nibble of the scanned digit |
| blanked_hi | output | 1 | Upper nibble is forced blank |
| blanked_lo | output | 1 | Lower nibble is forced blank |
| busy | output | 1 | Clear in progress |

## Verification
Some properties are checked by assertions on every cycle:
- the scan index steps by one, wraps at the last digit and holds without a step;
- the pointer advances once per accepted write and stays put while busy;
- a protected nibble leaves the write unchanged;
- a clear starts at byte 0 and leaves the whole store at zero when busy falls.

Other behaviour only shows through the bench's scenarios against its reference model:
- which byte is shown in which slot after a switch between eight and sixteen digits;
- the load-over-write and clear-over-write priorities;
- the blanking of each half;
- that no write slips in during the 16 busy cycles.

// File: rtl/disp_refresh_pkg.sv
package disp_refresh_pkg;
  localparam int NIB_W     = 4;
  localparam int BYTE_W    = 2 * NIB_W;
  localparam int DEPTH     = 16;
  localparam int AW        = $clog2(DEPTH);
  localparam int SMALL_DIG = 8;

  // next scan slot: wraps after the last digit of the selected count
  function automatic logic [AW-1:0] scan_next(input logic [AW-1:0] cur,
                                              input logic wide);
    logic [AW-1:0] last;
    last = wide ? AW'(DEPTH - 1) : AW'(SMALL_DIG - 1);
    return (cur >= last) ? '0 : cur + 1'b1;
  endfunction

  // combine a new byte with the old one, keeping protected halves
  function automatic logic [BYTE_W-1:0] nib_merge(input logic [BYTE_W-1:0] old_b,
                                                  input logic [BYTE_W-1:0] new_b,
                                                  input logic keep_hi,
                                                  input logic keep_lo);
    logic [BYTE_W-1:0] r;
    r[BYTE_W-1:NIB_W] = keep_hi ? old_b[BYTE_W-1:NIB_W] : new_b[BYTE_W-1:NIB_W];
    r[NIB_W-1:0]      = keep_lo ? old_b[NIB_W-1:0]      : new_b[NIB_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/disp_refresh_scan.sv
module disp_refresh_scan
  import disp_refresh_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_step,
  input  logic          digits16,
  output logic [AW-1:0] scan_idx
);
  logic [AW-1:0] last_idx;
  assign last_idx = digits16 ? AW'(DEPTH - 1) : AW'(SMALL_DIG - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)         scan_idx <= '0;
    else if (scan_step) scan_idx <= scan_next(scan_idx, digits16);
  end

  assert_scan_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_step && scan_idx == last_idx) |=> scan_idx == '0);
  assert_scan_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_step && scan_idx < last_idx) |=> scan_idx == $past(scan_idx) + 1'b1);
  assert_scan_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_step |=> $stable(scan_idx));
endmodule

// File: rtl/disp_refresh_store.sv
module disp_refresh_store
  import disp_refresh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_addr,
  input  logic              inh_hi,
  input  logic              inh_lo,
  input  logic              clr_req,
  input  logic [AW-1:0]     rd_idx,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              busy
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     clr_ptr;

  // named events for the assertions
  logic              clr_go, ld_go, wr_fire;
  logic [BYTE_W-1:0] cur_byte, wr_byte;
  logic [DEPTH*BYTE_W-1:0] store_flat;

  assign clr_go   = clr_req && !busy;
  assign ld_go    = ptr_load && !busy && !clr_req;
  assign wr_fire  = wr_en && !busy && !clr_req && !ptr_load;
  assign cur_byte = mem[wr_ptr];
  assign wr_byte  = nib_merge(cur_byte, wr_data, inh_hi, inh_lo);
  assign rd_byte  = mem[rd_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign store_flat[g*BYTE_W +: BYTE_W] = mem[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr  <= '0;
      clr_ptr <= '0;
      busy    <= 1'b0;
    end else if (busy) begin
      mem[clr_ptr] <= '0;
      clr_ptr      <= clr_ptr + 1'b1;
      if (clr_ptr == AW'(DEPTH - 1)) busy <= 1'b0;
    end else if (clr_go) begin
      busy    <= 1'b1;
      clr_ptr <= '0;
      wr_ptr  <= '0;
    end else if (ld_go) begin
      wr_ptr <= ptr_addr;
    end else if (wr_fire) begin
      mem[wr_ptr] <= wr_byte;
      wr_ptr      <= wr_ptr + 1'b1;
    end
  end

  assert_ptr_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> wr_ptr == $past(wr_ptr) + 1'b1);
  assert_keep_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && inh_hi) |-> wr_byte[BYTE_W-1:NIB_W] == cur_byte[BYTE_W-1:NIB_W]);
  assert_keep_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && inh_lo) |-> wr_byte[NIB_W-1:0] == cur_byte[NIB_W-1:0]);
  assert_clear_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (clr_ptr == '0 && wr_ptr == '0));
  assert_clear_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> store_flat == '0);
  assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wr_ptr));
endmodule

// File: rtl/disp_refresh_out.sv
module disp_refresh_out
  import disp_refresh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic [1:0]        blank_req,
  input  logic              busy,
  output logic [BYTE_W-1:0] nib_bus,
  output logic [1:0]        blank_eff
);
  // half 1 is the upper nibble, half 0 the lower one
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign blank_eff[h]               = blank_req[h] || busy;
    assign nib_bus[h*NIB_W +: NIB_W]  = blank_eff[h] ? '0 : rd_byte[h*NIB_W +: NIB_W];
  end

  assert_busy_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (nib_bus == '0));
endmodule

// File: rtl/disp_refresh.sv
module disp_refresh
  import disp_refresh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_step,
  input  logic              digits16,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_addr,
  input  logic              inh_hi,
  input  logic              inh_lo,
  input  logic              blank_hi,
  input  logic              blank_lo,
  input  logic              clr_req,
  output logic [AW-1:0]     scan_idx,
  output logic [NIB_W-1:0]  dig_hi,
  output logic [NIB_W-1:0]  dig_lo,
  output logic              blanked_hi,
  output logic              blanked_lo,
  output logic              busy
);
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] nib_bus;
  logic [1:0]        blank_eff;

  disp_refresh_scan u_scan (
    .clk(clk), .rst_n(rst_n), .scan_step(scan_step),
    .digits16(digits16), .scan_idx(scan_idx)
  );

  disp_refresh_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ptr_load(ptr_load), .ptr_addr(ptr_addr), .inh_hi(inh_hi), .inh_lo(inh_lo),
    .clr_req(clr_req), .rd_idx(scan_idx), .rd_byte(rd_byte), .busy(busy)
  );

  disp_refresh_out u_out (
    .clk(clk), .rst_n(rst_n), .rd_byte(rd_byte), .blank_req({blank_hi, blank_lo}),
    .busy(busy), .nib_bus(nib_bus), .blank_eff(blank_eff)
  );

  assign dig_hi     = nib_bus[BYTE_W-1:NIB_W];
  assign dig_lo     = nib_bus[NIB_W-1:0];
  assign blanked_hi = blank_eff[1];
  assign blanked_lo = blank_eff[0];
endmodule

// File: tb/disp_refresh_tb_top.sv
module disp_refresh_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_step = 0, digits16 = 1, wr_en = 0, ptr_load = 0;
  logic inh_hi = 0, inh_lo = 0, blank_hi = 0, blank_lo = 0, clr_req = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] ptr_addr = 0;
  logic [3:0] scan_idx, dig_hi, dig_lo;
  logic blanked_hi, blanked_lo, busy;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  disp_refresh dut_i (
    .clk(clk), .rst_n(rst_n), .scan_step(scan_step), .digits16(digits16),
    .wr_en(wr_en), .wr_data(wr_data), .ptr_load(ptr_load), .ptr_addr(ptr_addr),
    .inh_hi(inh_hi), .inh_lo(inh_lo), .blank_hi(blank_hi), .blank_lo(blank_lo),
    .clr_req(clr_req), .scan_idx(scan_idx), .dig_hi(dig_hi), .dig_lo(dig_lo),
    .blanked_hi(blanked_hi), .blanked_lo(blanked_lo), .busy(busy)
  );

  // behavioural reference model
  int m_idx = 0, m_ptr = 0, m_cptr = 0;
  bit m_busy = 0;
  int m_ram [16];

  initial for (int i = 0; i < 16; i++) m_ram[i] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_ptr = 0; m_cptr = 0; m_busy = 0;
      for (int i = 0; i < 16; i++) m_ram[i] = 0;
    end else begin
      if (scan_step) begin
        int last;
        last = digits16 ? 15 : 7;
        m_idx = (m_idx >= last) ? 0 : m_idx + 1;
      end
      if (m_busy) begin
        m_ram[m_cptr] = 0;
        if (m_cptr == 15) m_busy = 0;
        m_cptr = (m_cptr + 1) % 16;
      end else if (clr_req) begin
        m_busy = 1; m_cptr = 0; m_ptr = 0;
      end else if (ptr_load) begin
        m_ptr = ptr_addr;
      end else if (wr_en) begin
        int hi, lo;
        hi = inh_hi ? m_ram[m_ptr] / 16 : wr_data / 16;
        lo = inh_lo ? m_ram[m_ptr] % 16 : wr_data % 16;
        m_ram[m_ptr] = hi * 16 + lo;
        m_ptr = (m_ptr + 1) % 16;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %0d expected %0d at %0t", tag, cur_req, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    bit eh, el;
    eh = blank_hi || m_busy;
    el = blank_lo || m_busy;
    check("R2 scan_idx", scan_idx, m_idx);
    check("R5/R6 dig_hi", dig_hi, eh ? 0 : m_ram[m_idx] / 16);
    check("R5/R6 dig_lo", dig_lo, el ? 0 : m_ram[m_idx] % 16);
    check("R6 blanked_hi", blanked_hi, eh);
    check("R6 blanked_lo", blanked_lo, el);
    check("R7 busy", busy, m_busy);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R3 R5: fill all bytes in 16-digit mode, then scan through them
    cur_req = "R3";
    for (int i = 0; i < 16; i++) begin
      wr_en = 1; wr_data = 8'(i * 37 + 5);
      cyc(1);
    end
    wr_en = 0;
    cur_req = "R5";
    scan_step = 1;
    cyc(20);

    // R2: eight-digit mode, switched while the index is above 7
    cur_req = "R2";
    scan_step = 0;
    while (scan_idx < 4'd10) begin scan_step = 1; cyc(1); scan_step = 0; end
    digits16 = 0;
    cyc(1);
    scan_step = 1;
    cyc(19);
    for (int i = 0; i < 12; i++) begin scan_step = 1'(i % 3 == 0); cyc(1); end
    scan_step = 1;

    // R4: nibble protection
    cur_req = "R4";
    digits16 = 1;
    ptr_load = 1; ptr_addr = 4'd2; cyc(1); ptr_load = 0;
    inh_hi = 1; wr_en = 1; wr_data = 8'hA7; cyc(1);
    inh_hi = 0; inh_lo = 1; wr_data = 8'h3C; cyc(1);
    inh_hi = 1; wr_data = 8'hFF; cyc(1);
    inh_hi = 0; inh_lo = 0; wr_en = 0;
    cyc(18);

    // R3: load wins over a write in the same cycle, pointer wraps
    cur_req = "R3";
    ptr_load = 1; ptr_addr = 4'd15; wr_en = 1; wr_data = 8'h99; cyc(1);
    ptr_load = 0; wr_data = 8'h5A; cyc(1);
    wr_data = 8'hC3; cyc(1);
    wr_en = 0;
    cyc(17);

    // R6: blank each half on its own, store untouched
    cur_req = "R6";
    blank_hi = 1; cyc(17);
    blank_hi = 0; blank_lo = 1; cyc(17);
    blank_hi = 1; cyc(4);
    blank_hi = 0; blank_lo = 0; cyc(17);

    // R7 R8: clear wins over a write, then ignored traffic while busy
    cur_req = "R7";
    inh_hi = 1; inh_lo = 1;
    clr_req = 1; wr_en = 1; wr_data = 8'h11; cyc(1);
    clr_req = 0;
    cur_req = "R8";
    wr_data = 8'h22; cyc(5);
    ptr_load = 1; ptr_addr = 4'd9; clr_req = 1; cyc(3);
    ptr_load = 0; clr_req = 0; wr_en = 0;
    cyc(12);
    inh_hi = 0; inh_lo = 0;
    cur_req = "R7";
    cyc(18);

    // R3: pointer restarted at 0 after the clear
    cur_req = "R3";
    wr_en = 1; wr_data = 8'h81; cyc(1);
    wr_data = 8'h42; cyc(1);
    wr_en = 0;
    cyc(18);

    finish_run();
  end
endmodule